// File: doc/BRIEF.md
# Input Delay Eye-Centering Calibrator

This block trains the capture path of a four-channel, ten-bit-per-channel parallel converter interface. Each of the forty bit lanes has an adjustable input delay. The calibrator drives those delays and watches the captured data to set them. During a sweep, every lane sees the same tap setting, from 0 up to the maximum. At each setting the block waits for the delay to settle. It then checks a block of captured samples against a fixed training word.

For each lane it keeps the lowest and highest passing taps. When the sweep ends, it loads each lane with the midpoint of its passing window. Once every lane is centred, the converter sends a periodic marker word. The block measures which channel delivers the marker first and which last. It then holds the earlier channels back by whole sample words, so that all four present the marker in the same cycle. The aligned channels are released together as one forty-bit word.

A start pulse runs the whole procedure. Done and lock rise when the procedure succeeds. A fail flag and a per-lane error vector report the cases that cannot be calibrated.

Top module: `eye_align_cal`

## Requirements
- R1: After reset, every lane tap (tap_val bits 5l+4..5l for lane l) holds the mid value 16, and tap_load, done, lock, cal_fail and lane_err are all low.
- R2: After start, taps 0 to 31 are loaded in ascending order. Each load applies one value to all lanes and is marked by a tap_load pulse one cycle long. Consecutive sweep loads are 81 cycles apart: 1 load cycle, 16 settle cycles and 64 compare cycles.
- R3: A tap passes for lane l only if all 64 captured samples match bit b of the training word 10'h1B4, where lane l = 10c + b is lane_data[l]. A single mismatch in 64 rejects that tap.
- R4: After the sweep, a 33rd tap_load loads every lane that has a passing tap with floor((lowest passing + highest passing) / 2).
- R5: A lane with no passing tap gets its lane_err bit set and its tap left at 16. In that case cal_fail rises and done stays low.
- R6: After centring, channel c (lane_data bits 10c+9..10c) is compared with the marker word 10'h2E7. Each channel is delayed by the latest marker arrival minus its own arrival. word_out bits 10c+9..10c carry channel c's input from 1 + delay cycles earlier.
- R7: If the marker arrivals across the channels span more than 3 cycles, cal_fail rises, done stays low and lane_err stays zero.
- R8: Done and lock rise together once the aligned channels first show the marker in the same cycle. Done holds until the next start.
- R9: While locked, any cycle in which some but not all aligned channels show the marker clears lock, while done stays high.
- R10: A start pulse clears done, lock, cal_fail and lane_err in the next cycle and restarts the sweep at tap 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | One-cycle request to run calibration |
| lane_data | input | 40 | Captured bits; lane 10c+b is bit b of channel c |
| tap_load | output | 1 | Pulse: delay elements take tap_val |
| tap_val | output | 200 | Five-bit tap per lane, lane l at bits 5l+4..5l |
| done | output | 1 | Calibration completed successfully |
| lock | output | 1 | Aligned channels still agree on the marker |
| cal_fail | output | 1 | Calibration aborted |
| lane_err | output | 40 | Lanes that found no valid window |
| word_out | output | 40 | Skew-corrected combined sample word |

## Verification
The stand-in corrupts each lane outside its window. On the tap just outside each edge, it lets only one sample in 37 go wrong, so a design that accepted a mostly-clean tap would end up centred one step wide. The windows include ones starting at tap 0, one ending at tap 31, and one that is a single tap wide. These catch off-by-one and rounding errors in the midpoint arithmetic. Skews span exactly 3 cycles in one run and 4 in another, exposing an arrival window one cycle short or long. A drift of one channel after lock shows whether lock is really watched, and a lane with no window shows whether the failure path leaves that lane at mid-range.

// File: rtl/eyecal_pkg.sv
package eyecal_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_LOAD, ST_SETTLE, ST_CMP, ST_CENTER,
    ST_QUIET, ST_WIN, ST_EVAL, ST_VERIFY, ST_LOCKED, ST_FAIL
  } cal_state_e;

  // midpoint of a passing window, rounded down
  function automatic int center_tap(int first, int last);
    return (first + last) / 2;
  endfunction

  // extra word delay that brings a channel level with the latest one
  function automatic int align_delay(int latest, int own);
    return latest - own;
  endfunction

endpackage

// File: rtl/eye_lane_tracker.sv
module eye_lane_tracker #(
  parameter int TAP_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             cmp_en,
  input  logic             tap_end,
  input  logic [TAP_W-1:0] cur_tap,
  input  logic             sample,
  input  logic             expect_bit,
  output logic             found,
  output logic [TAP_W-1:0] first_tap,
  output logic [TAP_W-1:0] last_tap
);

  logic miss;
  logic bit_ok;
  logic tap_pass;

  assign bit_ok   = (sample == expect_bit);
  assign tap_pass = tap_end && !miss && bit_ok;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      miss      <= 1'b0;
      found     <= 1'b0;
      first_tap <= '0;
      last_tap  <= '0;
    end else if (cmp_en) begin
      if (tap_end) miss <= 1'b0;
      else if (!bit_ok) miss <= 1'b1;
      if (tap_pass) begin
        if (!found) first_tap <= cur_tap;
        last_tap <= cur_tap;
        found    <= 1'b1;
      end
    end
  end

  // R4
  window_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> (first_tap <= last_tap));

  // R3
  miss_blocks_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_en && tap_end && miss && !clear && found) |=> $stable(last_tap));

endmodule

// File: rtl/word_skew_line.sv
module word_skew_line #(
  parameter int W        = 10,
  parameter int MAX_SKEW = 3,
  parameter int SK_W     = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [W-1:0]    din,
  input  logic [SK_W-1:0] sel,
  output logic [W-1:0]    dout
);

  logic [W-1:0] hold [MAX_SKEW];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < MAX_SKEW; i++) hold[i] <= '0;
    end else begin
      hold[0] <= din;
      for (int i = 1; i < MAX_SKEW; i++) hold[i] <= hold[i-1];
    end
  end

  always_comb begin
    dout = din;
    for (int i = 1; i <= MAX_SKEW; i++)
      if (sel == SK_W'(i)) dout = hold[i-1];
  end

endmodule

// File: rtl/eye_align_cal.sv
module eye_align_cal
  import eyecal_pkg::*;
#(
  parameter int              CHANNELS   = 4,
  parameter int              BITS       = 10,
  parameter int              TAP_W      = 5,
  parameter int              SETTLE     = 16,
  parameter int              MATCH_N    = 64,
  parameter int              MAX_SKEW   = 3,
  parameter logic [BITS-1:0] TRAIN_WORD = 10'h1B4,
  parameter logic [BITS-1:0] MARK_WORD  = 10'h2E7
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             start,
  input  logic [CHANNELS*BITS-1:0]         lane_data,
  output logic                             tap_load,
  output logic [CHANNELS*BITS*TAP_W-1:0]   tap_val,
  output logic                             done,
  output logic                             lock,
  output logic                             cal_fail,
  output logic [CHANNELS*BITS-1:0]         lane_err,
  output logic [CHANNELS*BITS-1:0]         word_out
);

  localparam int LANES   = CHANNELS * BITS;
  localparam int TAP_MAX = (1 << TAP_W) - 1;
  localparam int TAP_MID = 1 << (TAP_W - 1);
  localparam int PHASE_W = $clog2(SETTLE + MATCH_N);
  localparam int SK_W    = $clog2(MAX_SKEW + 1);
  localparam int Q_W     = $clog2(MAX_SKEW + 2) + 1;

  cal_state_e         state;
  logic [TAP_W-1:0]   sweep_tap;
  logic [PHASE_W-1:0] phase;
  logic [Q_W-1:0]     qcnt;
  logic [SK_W-1:0]    wcnt;
  logic [LANES-1:0]   cap_q;
  logic [LANES-1:0]   expect_vec;
  logic [TAP_W-1:0]   tap_q    [LANES];
  logic               tap_load_q;
  logic               done_q, lock_q, fail_q;
  logic [LANES-1:0]   err_q;

  // named internal events
  logic               cmp_en, tap_end, trk_clear;
  logic               any_lane_bad, any_raw, al_any, al_all, al_split;
  logic [LANES-1:0]   lane_found;
  logic [TAP_W-1:0]   lane_first [LANES];
  logic [TAP_W-1:0]   lane_last  [LANES];
  logic [TAP_W-1:0]   lane_ctr   [LANES];
  logic [CHANNELS-1:0] mark_raw, mark_al, seen;
  logic [SK_W-1:0]    off      [CHANNELS];
  logic [SK_W-1:0]    dly      [CHANNELS];
  logic [SK_W-1:0]    dly_next [CHANNELS];
  logic [SK_W-1:0]    latest;

  assign expect_vec   = {CHANNELS{TRAIN_WORD}};
  assign cmp_en       = (state == ST_CMP);
  assign tap_end      = cmp_en && (phase == PHASE_W'(MATCH_N - 1));
  assign trk_clear    = start;
  assign any_lane_bad = ~&lane_found;
  assign any_raw      = |mark_raw;
  assign al_any       = |mark_al;
  assign al_all       = &mark_al;
  assign al_split     = al_any && !al_all;

  always_ff @(posedge clk) begin
    if (!rst_n) cap_q <= '0;
    else        cap_q <= lane_data;
  end

  // per-lane window search
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    eye_lane_tracker #(.TAP_W(TAP_W)) u_trk (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear      (trk_clear),
      .cmp_en     (cmp_en),
      .tap_end    (tap_end),
      .cur_tap    (sweep_tap),
      .sample     (cap_q[l]),
      .expect_bit (expect_vec[l]),
      .found      (lane_found[l]),
      .first_tap  (lane_first[l]),
      .last_tap   (lane_last[l])
    );
    assign lane_ctr[l] = TAP_W'(center_tap(int'(lane_first[l]), int'(lane_last[l])));
    assign tap_val[l*TAP_W +: TAP_W] = tap_q[l];
  end

  // per-channel word delay
  for (genvar c = 0; c < CHANNELS; c++) begin : g_chan
    word_skew_line #(.W(BITS), .MAX_SKEW(MAX_SKEW), .SK_W(SK_W)) u_line (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (cap_q[c*BITS +: BITS]),
      .sel   (dly[c]),
      .dout  (word_out[c*BITS +: BITS])
    );
    assign mark_raw[c] = (cap_q[c*BITS +: BITS] == MARK_WORD);
    assign mark_al[c]  = (word_out[c*BITS +: BITS] == MARK_WORD);
  end

  always_comb begin
    latest = '0;
    for (int c = 0; c < CHANNELS; c++)
      if (off[c] > latest) latest = off[c];
    for (int c = 0; c < CHANNELS; c++)
      dly_next[c] = SK_W'(align_delay(int'(latest), int'(off[c])));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      sweep_tap  <= '0;
      phase      <= '0;
      qcnt       <= '0;
      wcnt       <= '0;
      tap_load_q <= 1'b0;
      done_q     <= 1'b0;
      lock_q     <= 1'b0;
      fail_q     <= 1'b0;
      err_q      <= '0;
      seen       <= '0;
      for (int l = 0; l < LANES; l++) tap_q[l] <= TAP_W'(TAP_MID);
      for (int c = 0; c < CHANNELS; c++) begin
        off[c] <= '0;
        dly[c] <= '0;
      end
    end else begin
      tap_load_q <= 1'b0;
      if (start) begin
        state     <= ST_LOAD;
        sweep_tap <= '0;
        phase     <= '0;
        qcnt      <= '0;
        wcnt      <= '0;
        done_q    <= 1'b0;
        lock_q    <= 1'b0;
        fail_q    <= 1'b0;
        err_q     <= '0;
        seen      <= '0;
      end else begin
        case (state)
          ST_LOAD: begin
            for (int l = 0; l < LANES; l++) tap_q[l] <= sweep_tap;
            tap_load_q <= 1'b1;
            phase      <= '0;
            state      <= ST_SETTLE;
          end
          ST_SETTLE: begin
            if (phase == PHASE_W'(SETTLE - 1)) begin
              phase <= '0;
              state <= ST_CMP;
            end else begin
              phase <= phase + 1'b1;
            end
          end
          ST_CMP: begin
            if (tap_end) begin
              phase <= '0;
              if (sweep_tap == TAP_W'(TAP_MAX)) begin
                state <= ST_CENTER;
              end else begin
                sweep_tap <= sweep_tap + 1'b1;
                state     <= ST_LOAD;
              end
            end else begin
              phase <= phase + 1'b1;
            end
          end
          ST_CENTER: begin
            for (int l = 0; l < LANES; l++)
              tap_q[l] <= lane_found[l] ? lane_ctr[l] : TAP_W'(TAP_MID);
            err_q      <= ~lane_found;
            tap_load_q <= 1'b1;
            qcnt       <= '0;
            if (any_lane_bad) begin
              fail_q <= 1'b1;
              state  <= ST_FAIL;
            end else begin
              state  <= ST_QUIET;
            end
          end
          ST_QUIET: begin
            if (any_raw) begin
              if (qcnt == Q_W'(MAX_SKEW + 1)) begin
                seen  <= mark_raw;
                for (int c = 0; c < CHANNELS; c++) off[c] <= '0;
                wcnt  <= SK_W'(1);
                state <= ST_WIN;
              end else begin
                qcnt <= '0;
              end
            end else if (qcnt != Q_W'(MAX_SKEW + 1)) begin
              qcnt <= qcnt + 1'b1;
            end
          end
          ST_WIN: begin
            for (int c = 0; c < CHANNELS; c++)
              if (mark_raw[c] && !seen[c]) begin
                seen[c] <= 1'b1;
                off[c]  <= wcnt;
              end
            if (wcnt == SK_W'(MAX_SKEW)) state <= ST_EVAL;
            else                         wcnt  <= wcnt + 1'b1;
          end
          ST_EVAL: begin
            if (&seen) begin
              for (int c = 0; c < CHANNELS; c++) dly[c] <= dly_next[c];
              state <= ST_VERIFY;
            end else begin
              fail_q <= 1'b1;
              state  <= ST_FAIL;
            end
          end
          ST_VERIFY: begin
            if (al_any) begin
              if (al_all) begin
                done_q <= 1'b1;
                lock_q <= 1'b1;
                state  <= ST_LOCKED;
              end else begin
                fail_q <= 1'b1;
                state  <= ST_FAIL;
              end
            end
          end
          ST_LOCKED: begin
            if (al_split) lock_q <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  assign tap_load = tap_load_q;
  assign done     = done_q;
  assign lock     = lock_q;
  assign cal_fail = fail_q;
  assign lane_err = err_q;

  // R2
  tap_load_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tap_load |=> !tap_load);

  // R8
  lock_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock |-> done);

  // R8
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  // R5
  done_excl_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !cal_fail);

  // R10
  start_clears_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!done && !cal_fail && lane_err == '0));

  // R9
  split_drops_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (al_split && lock && !start) |=> (!lock && done));

endmodule

// File: tb/tb_eye_align_cal.sv
`timescale 1ns/100ps
module tb_eye_align_cal;

  localparam int CH = 4, BITS = 10, LANES = 40, TW = 5, MK_PER = 16;
  localparam logic [9:0] TRAIN = 10'h1B4, MARK = 10'h2E7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [LANES-1:0] lane_data = '0;
  logic tap_load, done, lock, cal_fail;
  logic [LANES*TW-1:0] tap_val;
  logic [LANES-1:0] lane_err, word_out;

  always #2.5 clk = ~clk;

  eye_align_cal dut (
    .clk(clk), .rst_n(rst_n), .start(start), .lane_data(lane_data),
    .tap_load(tap_load), .tap_val(tap_val), .done(done), .lock(lock),
    .cal_fail(cal_fail), .lane_err(lane_err), .word_out(word_out)
  );

  int vectors = 0, miscompares = 0;
  int lo[LANES], hi[LANES], btap[LANES];
  int skew[CH], dexp[CH];
  logic [9:0] hist[CH][8];
  int kcnt = 100, loads = 0, last_load = 0, cyc = 0;
  bit mon_on = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic bit corrupt(int l, int t, int k);
    if (t >= lo[l] && t <= hi[l]) return 1'b0;
    if (t == lo[l] - 1 || t == hi[l] + 1) return (k % 37) == 0;
    return 1'b1;
  endfunction

  // behavioural stand-in for delay elements and converter, plus per-clock monitor
  initial begin
    for (int l = 0; l < LANES; l++) btap[l] = 16;
    for (int c = 0; c < CH; c++) for (int j = 0; j < 8; j++) hist[c][j] = TRAIN;
    forever begin
      @(negedge clk);
      cyc++;
      if (cyc > 60000) begin
        miscompares++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 60000);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
      end
      if (rst_n && done && mon_on)
        for (int c = 0; c < CH; c++)
          chk(word_out[c*BITS +: BITS] == hist[c][dexp[c]], "R6 aligned word",
              int'(word_out[c*BITS +: BITS]), int'(hist[c][dexp[c]]));
      if (rst_n && tap_load) begin
        loads++;
        if (loads <= 32) begin
          bit same = 1'b1;
          for (int l = 0; l < LANES; l++)
            if (int'(tap_val[l*TW +: TW]) != loads - 1) same = 1'b0;
          chk(same, "R2 sweep tap value", int'(tap_val[TW-1:0]), loads - 1);
          if (loads > 1) chk(cyc - last_load == 81, "R2 load spacing", cyc - last_load, 81);
        end
        last_load = cyc;
        for (int l = 0; l < LANES; l++) btap[l] = int'(tap_val[l*TW +: TW]);
      end
      kcnt++;
      begin
        logic [LANES-1:0] nxt;
        for (int c = 0; c < CH; c++) begin
          logic [9:0] w;
          w = (loads >= 33 && ((kcnt - skew[c]) % MK_PER) == 0) ? MARK : TRAIN;
          for (int j = 7; j > 0; j--) hist[c][j] = hist[c][j-1];
          hist[c][0] = w;
          for (int b = 0; b < BITS; b++)
            nxt[c*BITS + b] = w[b] ^ corrupt(c*BITS + b, btap[c*BITS + b], kcnt);
        end
        lane_data = nxt;
      end
    end
  end

  task automatic run_cal();
    int mx;
    mon_on = 1'b0;
    @(negedge clk); start = 1'b1; loads = 0;
    @(negedge clk); start = 1'b0;
    chk(!done && !cal_fail && lane_err == '0, "R10 start clears status", int'(done), 0);
    mx = 0;
    for (int c = 0; c < CH; c++) if (skew[c] > mx) mx = skew[c];
    for (int c = 0; c < CH; c++) dexp[c] = (mx - skew[c] > 3) ? 0 : mx - skew[c];
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (done || cal_fail) break;
    end
    mon_on = 1'b1;
  endtask

  task automatic check_taps(input string tag);
    for (int l = 0; l < LANES; l++) begin
      int e = (lo[l] > hi[l]) ? 16 : (lo[l] + hi[l]) / 2;
      chk(int'(tap_val[l*TW +: TW]) == e, tag, int'(tap_val[l*TW +: TW]), e);
    end
  endtask

  initial begin
    for (int l = 0; l < LANES; l++) begin
      lo[l] = 3 + (l * 7) % 12;
      hi[l] = lo[l] + 2 + (l * 5) % 9;
    end
    skew = '{1, 3, 0, 2};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!tap_load && !done && !lock && !cal_fail, "R1 reset flags", int'({tap_load, done, lock, cal_fail}), 0);
    chk(lane_err == '0, "R1 reset lane_err", int'(lane_err[31:0]), 0);
    for (int l = 0; l < LANES; l++)
      chk(int'(tap_val[l*TW +: TW]) == 16, "R1 reset tap", int'(tap_val[l*TW +: TW]), 16);

    // run A: normal windows, skew spanning 3 words
    run_cal();
    chk(done && lock && !cal_fail, "R8 done and lock", int'({done, lock, cal_fail}), 6);
    check_taps("R3 R4 centre tap");
    repeat (100) @(negedge clk);
    chk(done && lock, "R8 done holds", int'({done, lock}), 3);
    // R9 drift channel 2 by one word
    skew[2] = skew[2] + 1;
    repeat (60) @(negedge clk);
    chk(!lock, "R9 lock drops", int'(lock), 0);
    chk(done, "R9 done stays", int'(done), 1);

    // run B: edge windows, restart
    for (int l = 0; l < LANES; l++) begin
      lo[l] = 8 + (l * 3) % 10;
      hi[l] = lo[l] + 1 + (l % 7);
    end
    lo[0] = 0;  hi[0] = 31;
    lo[1] = 20; hi[1] = 20;
    lo[2] = 25; hi[2] = 31;
    skew = '{0, 0, 2, 2};
    run_cal();
    chk(done && lock && !cal_fail, "R10 restart succeeds", int'({done, lock, cal_fail}), 6);
    check_taps("R3 R4 edge centre tap");
    repeat (80) @(negedge clk);

    // run C: lane 13 has no window
    for (int l = 0; l < LANES; l++) begin
      lo[l] = 3 + (l * 7) % 12;
      hi[l] = lo[l] + 2 + (l * 5) % 9;
    end
    lo[13] = 99; hi[13] = -1;
    skew = '{1, 3, 0, 2};
    run_cal();
    chk(cal_fail && !done && !lock, "R5 fail flags", int'({cal_fail, done, lock}), 4);
    chk(lane_err == (40'd1 << 13), "R5 lane_err", int'(lane_err[31:0]), 1 << 13);
    check_taps("R5 taps after missing window");

    // run D: skew span of 4 words
    lo[13] = 5; hi[13] = 12;
    skew = '{0, 4, 1, 1};
    run_cal();
    chk(cal_fail && !done && !lock, "R7 skew too wide", int'({cal_fail, done, lock}), 4);
    chk(lane_err == '0, "R7 lane_err clear", int'(lane_err[31:0]), 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule